// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

A purely combinational integer arithmetic logic unit for a simple load/store processor datapath. It takes two operand words and a 4-bit operation selector. It returns a result word, a flag that is set when the result is all zeros, and a signed-overflow flag. Immediates are widened before they reach this block. Shifts, multiply and divide are handled elsewhere, and so is any trap raised from the overflow flag.

Add and subtract share one ripple-carry adder. Subtraction inverts the second operand and forces the carry-in high. A small bitwise unit covers the four logic operations, and a final selector picks among the adder sum, the bitwise output and the two compare bits. The zero flag is taken from the selected result, so a subtract followed by a test of the zero flag checks two operands for equality.

Top module: `int_alu`

## Requirements
- R1: For opcode 0x0 (signed add) and 0x1 (unsigned add), `res` equals `opa + opb` modulo 2^W.
- R2: For opcode 0x2 (signed subtract) and 0x3 (unsigned subtract), `res` equals `opa - opb` modulo 2^W.
- R3: For opcodes 0x0 and 0x2, `ovf` is 1 exactly when the two's-complement result is outside the signed W-bit range, that is, when the carry into the top bit differs from the carry out of it.
- R4: `ovf` is 0 for every opcode other than 0x0 and 0x2, including unsigned add/subtract, the logic operations and the compares.
- R5: Opcodes 0x4, 0x5, 0x6 and 0x7 give the bitwise AND, OR, XOR and NOR of the operands.
- R6: Opcode 0xA (signed less-than) gives `res` = 1 when `opa < opb` as signed numbers and 0 otherwise, with bits W-1..1 at 0. The compare is correct even when `opa - opb` overflows.
- R7: Opcode 0xB (unsigned less-than) gives `res` = 1 when `opa < opb` as unsigned numbers and 0 otherwise, with bits W-1..1 at 0.
- R8: `is_zero` is 1 exactly when every bit of `res` is 0, for every opcode. After a subtract it is 1 exactly when the operands are equal.
- R9: Opcodes 0x8, 0x9 and 0xC to 0xF give `res` = 0 and `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (32) | First operand |
| opb | input | W (32) | Second operand |
| opcode | input | 4 | Operation selector |
| res | output | W (32) | Selected result word |
| is_zero | output | 1 | High when `res` is all zeros |
| ovf | output | 1 | Signed overflow for signed add and subtract |

## Verification
The bound checker tests five things whenever an input changes: overflow stays low outside signed add and subtract, the compare results have clear upper bits and match signed and unsigned comparisons, unused opcodes return zero, and the zero flag after a subtract tracks operand equality. Only the bench scenarios show the boundary operand values: the most positive and most negative words, carry-out without signed overflow, and a signed compare whose subtraction overflows. The bench then runs random operands through every opcode against its own arithmetic model to cover the exact result words of all ten operations.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } alu_op_e;
endpackage

// File: rtl/int_alu_adder.sv
// Ripple-carry adder made from one full-adder cell per bit.
module int_alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_top_in,
  output logic         c_out
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
  end

  assign c_top_in = carry[W-1];
  assign c_out    = carry[W];
endmodule

// File: rtl/int_alu_logic.sv
// Bitwise unit; sel chooses AND, OR, XOR, NOR.
module int_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [OP_W-1:0] opcode,
  output logic [W-1:0]    res,
  output logic            is_zero,
  output logic            ovf
);
  logic         do_sub;
  logic         signed_op;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         c_top_in;
  logic         c_out;
  logic         raw_ovf;
  logic [W-1:0] logic_y;
  logic         lt_signed;
  logic         lt_unsigned;

  always_comb begin
    do_sub    = (opcode == OP_SUB) || (opcode == OP_SUBU) ||
                (opcode == OP_SLT) || (opcode == OP_SLTU);
    signed_op = (opcode == OP_ADD) || (opcode == OP_SUB);
    b_eff     = opb ^ {W{do_sub}};
  end

  int_alu_adder #(.W(W)) u_adder (
    .a        (opa),
    .b        (b_eff),
    .cin      (do_sub),
    .sum      (sum),
    .c_top_in (c_top_in),
    .c_out    (c_out)
  );

  int_alu_logic #(.W(W)) u_logic (
    .a   (opa),
    .b   (opb),
    .sel (opcode[1:0]),
    .y   (logic_y)
  );

  always_comb begin
    raw_ovf     = c_top_in ^ c_out;
    // sign of the difference, corrected when the subtraction overflowed
    lt_signed   = sum[W-1] ^ raw_ovf;
    // no carry out of A + ~B + 1 means a borrow
    lt_unsigned = ~c_out;
  end

  always_comb begin
    res = '0;
    unique case (opcode)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: res = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    res = logic_y;
      OP_SLT:                           res[0] = lt_signed;
      OP_SLTU:                          res[0] = lt_unsigned;
      default:                          res = '0;
    endcase
  end

  assign ovf     = raw_ovf & signed_op;
  assign is_zero = ~|res;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   opcode,
  input logic [W-1:0] res,
  input logic         is_zero,
  input logic         ovf
);
  always_comb begin
    if (opcode != 4'h0 && opcode != 4'h2) begin
      a_r4_no_overflow: assert (!ovf)
        else $error("overflow raised for opcode %h", opcode);
    end
    if (opcode == 4'h2 || opcode == 4'h3) begin
      a_r8_sub_equal: assert (is_zero == (opa == opb))
        else $error("zero flag after subtract disagrees with equality");
    end
    if (opcode == 4'hA) begin
      a_r6_slt_value: assert (res == W'($signed(opa) < $signed(opb)))
        else $error("signed compare wrong");
    end
    if (opcode == 4'hB) begin
      a_r7_sltu_value: assert (res == W'(opa < opb))
        else $error("unsigned compare wrong");
    end
    if (opcode == 4'h8 || opcode == 4'h9 || opcode >= 4'hC) begin
      a_r9_unused_quiet: assert (res == '0 && !ovf && is_zero)
        else $error("unused opcode produced output");
    end
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .opa     (opa),
  .opb     (opb),
  .opcode  (opcode),
  .res     (res),
  .is_zero (is_zero),
  .ovf     (ovf)
);

// File: tb/int_alu_tb.sv
`timescale 1ns/1ps
module int_alu_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [3:0]   opcode = 4'h0;
  logic [W-1:0] res;
  logic         is_zero;
  logic         ovf;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  int_alu #(.W(W)) u_dut (
    .opa(opa), .opb(opb), .opcode(opcode),
    .res(res), .is_zero(is_zero), .ovf(ovf)
  );

  function automatic void model(input logic [3:0] op, input logic [W-1:0] a,
                                input logic [W-1:0] b, output logic [W-1:0] r,
                                output logic v);
    r = '0;
    v = 1'b0;
    case (op)
      4'h0: begin r = a + b; v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); end
      4'h1: r = a + b;
      4'h2: begin r = a - b; v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); end
      4'h3: r = a - b;
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b);
      4'hA: r[0] = ($signed(a) < $signed(b));
      4'hB: r[0] = (a < b);
      default: r = '0;
    endcase
  endfunction

  task automatic run(input string tag, input logic [3:0] op,
                     input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] er;
    logic         ev;
    @(negedge clk);
    opa = a; opb = b; opcode = op;
    #1;
    model(op, a, b, er, ev);
    checks++;
    if (res !== er || is_zero !== (er == '0) || ovf !== ev) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h: res=%h z=%b v=%b expected res=%h z=%b v=%b",
               tag, op, a, b, res, is_zero, ovf, er, (er == '0), ev);
    end
  endtask

  task automatic t_idle_state;
    @(negedge clk); #1;
    checks++;
    if (res !== '0 || is_zero !== 1'b1 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R8 idle: res=%h z=%b v=%b expected res=0 z=1 v=0", res, is_zero, ovf);
    end
  endtask

  task automatic t_add;
    run("R1", 4'h0, 32'd5, 32'd7);
    run("R3", 4'h0, 32'h7fff_ffff, 32'd1);
    run("R3", 4'h0, 32'h8000_0000, 32'h8000_0000);
    run("R3", 4'h0, 32'hffff_ffff, 32'd1);
    run("R4", 4'h1, 32'h7fff_ffff, 32'd1);
    run("R1", 4'h1, 32'hffff_ffff, 32'd1);
  endtask

  task automatic t_sub;
    run("R2", 4'h2, 32'd9, 32'd4);
    run("R8", 4'h2, 32'h1234_5678, 32'h1234_5678);
    run("R3", 4'h2, 32'h8000_0000, 32'd1);
    run("R3", 4'h2, 32'h7fff_ffff, 32'hffff_ffff);
    run("R4", 4'h3, 32'h8000_0000, 32'd1);
    run("R2", 4'h3, 32'd0, 32'd1);
  endtask

  task automatic t_logic;
    run("R5", 4'h4, 32'hf0f0_ff00, 32'h0ff0_f0f0);
    run("R5", 4'h5, 32'hf0f0_ff00, 32'h0ff0_f0f0);
    run("R5", 4'h6, 32'hdead_beef, 32'hdead_beef);
    run("R5", 4'h7, 32'h0000_0000, 32'h0000_0000);
    run("R5", 4'h7, 32'hffff_0000, 32'h0000_ffff);
  endtask

  task automatic t_slt;
    run("R6", 4'hA, 32'hffff_ffff, 32'd1);
    run("R6", 4'hA, 32'h8000_0000, 32'd1);
    run("R6", 4'hA, 32'h7fff_ffff, 32'hffff_ffff);
    run("R6", 4'hA, 32'd3, 32'd3);
    run("R6", 4'hA, 32'h8000_0000, 32'h7fff_ffff);
  endtask

  task automatic t_sltu;
    run("R7", 4'hB, 32'hffff_ffff, 32'd1);
    run("R7", 4'hB, 32'd1, 32'hffff_ffff);
    run("R7", 4'hB, 32'd0, 32'd0);
    run("R7", 4'hB, 32'h8000_0000, 32'h7fff_ffff);
  endtask

  task automatic t_unused;
    foreach (opa[i]) begin end
    for (int op = 8; op < 16; op++) begin
      if (op != 10 && op != 11)
        run("R9", 4'(op), 32'h7fff_ffff, 32'h7fff_ffff);
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 150; n++) begin
      for (int op = 0; op < 16; op++) begin
        logic [W-1:0] a = $urandom;
        logic [W-1:0] b = (n % 5 == 0) ? a : $urandom;
        run("R1-R9 random", 4'(op), a, b);
      end
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle_state();
    t_add();
    t_sub();
    t_logic();
    t_slt();
    t_sltu();
    t_unused();
    t_random();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule